// File: doc/BRIEF.md
# Cascadable Programmable Down-Count Divider

This block divides a clock by a programmable ratio. It is built from identical 6-bit down-counter slices chained into one wide counter. A slice steps down only when every slice below it reads zero. Each slice reports a local zero flag as a lookahead carry, so a slice's enable comes from one wide AND of the lower flags and not from a ripple chain. When every slice reads zero, the terminal-count signal is active. That signal drives the shared load select of all slices, so the whole chain takes the reload value together on the next edge.

The reload value is the ratio minus one, because the reload itself uses one clock edge. A reload value of R therefore gives a terminal pulse once every R+1 clocks. Ratios run from 2 up to 2^(6*SLICES). A polarity input selects whether the divided output is the terminal pulse itself or its complement. A reload value of zero makes the counter sit at zero, which is divide-by-one, and a flag marks that setting as illegal. A synchronous reset loads the reload value, so the first output period already has the right length.

Top module: `casc_down_divider`

## Requirements
- R1: With `srst` high at a clock edge, `count` equals `reload_val` after that edge.
- R2: Away from terminal count, `count` falls by exactly one per clock. This includes the borrow across a slice boundary, where the lower slices go from 0 to all ones and the upper slice drops by one (reload 64 gives 63 one clock later).
- R3: `tc` is high exactly when `count` is all zeros. At the edge where `tc` is high, `count` is reloaded with `reload_val`.
- R4: For a nonzero reload value R, `tc` is high for one clock in every R+1 clocks. This holds for R from 1 (divide by 2) up to 2^W-1 (the largest ratio).
- R5: `div_out` equals `tc` when `inv_sel` is 0 and equals the inverse of `tc` when `inv_sel` is 1.
- R6: `bad_cfg` is high whenever `reload_val` is zero. Once the counter holds zero with a zero reload value, `tc` stays high on every clock (divide by one).
- R7: A change of `reload_val` in the middle of a period does not disturb the running count. The new value is taken only at the next terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| srst | input | 1 | Synchronous reset; loads the reload value |
| reload_val | input | 6*SLICES | Divide ratio minus one |
| inv_sel | input | 1 | 1 selects the inverted divided output |
| count | output | 6*SLICES | Current counter value, all slices |
| tc | output | 1 | Terminal count: whole chain at zero |
| div_out | output | 1 | Divided output, polarity set by `inv_sel` |
| bad_cfg | output | 1 | Reload value of zero (illegal divide by one) |

## Verification
`tc`, `div_out` and `bad_cfg` are combinational, so they are valid in the same cycle as the count or input that causes them. `count` changes one edge after reset, a load or a step. The bench changes inputs and samples outputs only on falling edges. A value caused by the rising edge in between is therefore read at the next falling edge, and one falling edge is counted for each rising edge. A period is measured as the number of falling edges from one high sample of `tc` to the next, so it must equal the reload value plus one.

// File: rtl/casc_down_divider.sv
module casc_down_divider #(
  parameter int SLICE_W = 6,
  parameter int SLICES  = 4,
  localparam int W      = SLICE_W * SLICES
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [W-1:0] reload_val,
  input  logic         inv_sel,
  output logic [W-1:0] count,
  output logic         tc,
  output logic         div_out,
  output logic         bad_cfg
);

  logic [SLICES:0]   en;
  logic [SLICES-1:0] is_zero;
  logic              load;

  assign en[0] = 1'b1;
  assign load  = srst | tc;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    logic [SLICE_W-1:0] q;

    assign is_zero[i] = (q == '0);
    assign en[i+1]    = &is_zero[i:0];
    assign count[i*SLICE_W +: SLICE_W] = q;

    always_ff @(posedge clk) begin
      if (load)
        q <= reload_val[i*SLICE_W +: SLICE_W];
      else if (en[i])
        q <= q - 1'b1;
    end
  end

  assign tc      = en[SLICES];
  assign div_out = tc ^ inv_sel;
  assign bad_cfg = (reload_val == '0);

  // R1
  rst_load_chk: assert property (@(posedge clk)
    srst |=> count == $past(reload_val));

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (srst)
    !tc |=> count == $past(count) - 1'b1);

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (srst)
    tc |=> count == $past(reload_val));

  // R3
  tc_zero_chk: assert property (@(posedge clk) disable iff (srst)
    tc |-> count == '0);

  // R6
  div_one_chk: assert property (@(posedge clk) disable iff (srst)
    (tc && reload_val == '0) |=> tc);

endmodule

// File: tb/test_casc_down_divider.sv
module test_casc_down_divider;
  localparam int SW = 6;
  localparam int NS = 2;
  localparam int W  = SW * NS;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic [W-1:0] reload_val = 12'd10;
  logic inv_sel = 1'b0;
  logic [W-1:0] count;
  logic tc, div_out, bad_cfg;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  casc_down_divider #(.SLICE_W(SW), .SLICES(NS)) i_casc_down_divider (
    .clk(clk), .srst(srst), .reload_val(reload_val), .inv_sel(inv_sel),
    .count(count), .tc(tc), .div_out(div_out), .bad_cfg(bad_cfg)
  );

  // {reload value, polarity, expected period}
  localparam logic [W+W:0] VEC [6] = '{
    {12'd1,    1'b0, 12'd2},
    {12'd36,   1'b1, 12'd37},
    {12'd63,   1'b0, 12'd64},
    {12'd64,   1'b1, 12'd65},
    {12'd200,  1'b0, 12'd201},
    {12'd4095, 1'b1, 12'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [W-1:0] r);
    @(negedge clk);
    reload_val = r;
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
  endtask

  task automatic wait_tc();
    for (int k = 0; k < 5000 && !tc; k++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int v = 0; v < 6; v++) begin
      logic [W-1:0] r;
      logic pol;
      int exp_per, per;
      r = VEC[v][W+W:W+1];
      pol = VEC[v][W];
      exp_per = (VEC[v][W-1:0] == '0) ? (1 << W) : int'(VEC[v][W-1:0]);
      inv_sel = pol;
      do_reset(r);
      chk("R1 count after reset", count, r);
      chk("R5 div_out off terminal", div_out, pol);
      wait_tc();
      chk("R3 tc at zero count", count, 0);
      chk("R5 div_out at terminal", div_out, !pol);
      per = 0;
      do begin
        @(negedge clk);
        per++;
      end while (!tc && per < 5000);
      chk("R4 output period", per, exp_per);
      @(negedge clk);
      chk("R3 reload after terminal", count, r);
    end

    inv_sel = 1'b0;
    do_reset(12'd64);
    chk("R1 reset to 64", count, 64);
    @(negedge clk);
    chk("R2 borrow 64 to 63", count, 63);
    do_reset(12'd128);
    @(negedge clk);
    chk("R2 borrow 128 to 127", count, 127);
    @(negedge clk);
    chk("R2 plain step", count, 126);

    do_reset(12'd100);
    repeat (10) @(negedge clk);
    chk("R2 ten steps", count, 90);
    reload_val = 12'd5;
    @(negedge clk);
    chk("R7 running count kept", count, 89);
    chk("R6 flag low for nonzero", bad_cfg, 0);
    wait_tc();
    @(negedge clk);
    chk("R7 new value at reload", count, 5);

    do_reset(12'd0);
    chk("R6 illegal flag", bad_cfg, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R6 tc every clock", tc, 1);
      @(negedge clk);
    end
    chk("R6 count held at zero", count, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule